// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory

This block is a word store with 16-bit addresses and 16-bit data, built from four banks that run independently. Addresses are byte addresses of 16-bit words. The two low bits of the word address choose the bank, so consecutive words land in consecutive banks. The block takes at most one request per clock. A request is an address, write data, a write strobe and a read strobe. It sends the request to its bank. That bank then stays occupied for four cycles.

A request that finds its bank occupied is dropped, and `stall` is raised in the same cycle. A malformed request is also dropped, and `err` is raised. A request is malformed if it has both strobes set or an odd address. Read data for an accepted read appears on `rdata` two cycles after the request, for exactly one cycle. At all other times `rdata` is zero. A caller that walks addresses in order therefore gets one access per cycle. A caller that hammers one bank gets one access every four cycles.

The bank count is fixed at four. The stored depth per bank is set by `IDX_W`, and higher address bits alias onto it. `IDX_W = 13` gives the full 64 KB. The default keeps the store small.

Top module: `ilv_mem4`

## Requirements
- R1: The bank is `addr[2:1]`. The per-bank word index is `addr[IDX_W+2:3]`. At most one bank starts an access per cycle.
- R2: While `rst` is high on a rising edge, every bank timer, every stored word and the `rdata` register are cleared. `stall` and `err` are 0 for as long as `rst` is high, even if a request is present.
- R3: An access accepted in cycle N sets `busy[bank]` to 1 in cycles N+1, N+2 and N+3. It clears it in cycle N+4, unless the bank accepts again.
- R4: A legal request to a bank whose `busy` bit is 1 raises `stall` in that same cycle and is not performed.
- R5: A legal request to a bank whose `busy` bit is 0 is accepted in any cycle, including the cycle right after an access to another bank.
- R6: A read accepted in cycle N drives the stored word onto `rdata` in cycle N+2 only. In every other cycle `rdata` is 0.
- R7: `rd` and `wr` both 1 raises `err` in that cycle. No access is performed and `stall` stays 0.
- R8: A request (`rd` or `wr` high) with `addr[0]` = 1 raises `err` in that cycle and is not performed.
- R9: A stalled or erroneous request changes no bank timer, no stored word and no `rdata` value.
- R10: An accepted write stores `wdata` at its word. Later reads of that word return it until it is overwritten or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Byte address of the 16-bit word |
| wdata | input | 16 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 16 | Read result, two cycles after the read |
| stall | output | 1 | Request hit an occupied bank and was dropped |
| busy | output | 4 | Per-bank occupied flags |
| err | output | 1 | Malformed request dropped |

## Verification
Two things can land in the same cycle. One is a rejection, a stall or an error, of the request presented now. The other is the return of data from a read accepted two cycles earlier, often from that very bank. A pseudo-random phase mixes reads, writes, bank repeats and malformed requests, and many cycles end up carrying both a rejection and a read return. A directed case sets this up on purpose: a read, then a write to the same bank that is stalled while the read's data is due. The bench models bank timers, the stored contents and a two-stage return pipe from the requirements. It judges `stall`, `err`, `busy` and `rdata` in every cycle, so a dropped request that disturbs the returning word or a timer is caught at the ports.

// File: rtl/ilv_mem4_pkg.sv
package ilv_mem4_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int NBANK  = 4;
    localparam int BANK_W = $clog2(NBANK);

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mreq_t;

    typedef enum logic [1:0] {
        K_IDLE  = 2'd0,
        K_READ  = 2'd1,
        K_WRITE = 2'd2,
        K_BAD   = 2'd3
    } req_kind_e;

    // word address low bits pick the bank (addr bit 0 is the byte bit)
    function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
        return a[BANK_W:1];
    endfunction

    function automatic req_kind_e classify(input mreq_t r);
        if (r.rd && r.wr)                 return K_BAD;
        else if ((r.rd || r.wr) && r.addr[0]) return K_BAD;
        else if (r.rd)                    return K_READ;
        else if (r.wr)                    return K_WRITE;
        else                              return K_IDLE;
    endfunction

endpackage

// File: rtl/mb_decode.sv
module mb_decode
    import ilv_mem4_pkg::*;
(
    input  logic             rst,
    input  mreq_t            req,
    input  logic [NBANK-1:0] busy,
    output logic [NBANK-1:0] accept,
    output logic             is_wr,
    output logic             stall,
    output logic             err
);
    req_kind_e         kind;
    logic [BANK_W-1:0] bsel;
    logic              legal;

    always_comb begin
        kind   = rst ? K_IDLE : classify(req);
        bsel   = bank_of(req.addr);
        legal  = (kind == K_READ) || (kind == K_WRITE);
        err    = (kind == K_BAD);
        stall  = legal && busy[bsel];
        is_wr  = (kind == K_WRITE);
        accept = '0;
        if (legal && !busy[bsel])
            accept[bsel] = 1'b1;
    end
endmodule

// File: rtl/mb_bank.sv
module mb_bank
    import ilv_mem4_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int OCC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              is_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int CNT_W = $clog2(OCC_CYC);

    logic [CNT_W-1:0]  occ;
    logic [DATA_W-1:0] store [DEPTH];

    assign busy = (occ != '0);

    always_ff @(posedge clk) begin
        if (rst)
            occ <= '0;
        else if (accept)
            occ <= CNT_W'(OCC_CYC - 1);
        else if (busy)
            occ <= occ - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                store[i] <= '0;
        end else if (accept && is_wr) begin
            store[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= accept && !is_wr;
            rdata  <= (accept && !is_wr) ? store[idx] : '0;
        end
    end

    // R4: the decoder never starts an access in an occupied bank
    p_no_accept_busy_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> !accept);

    // R3: a started access leaves the bank occupied in the next cycle
    p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    // R9: a rejected or idle cycle never writes the store contents out
    p_quiet_return_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !rvalid);
endmodule

// File: rtl/mb_rdret.sv
module mb_rdret
    import ilv_mem4_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NBANK-1:0]             rvalid,
    input  logic [NBANK-1:0][DATA_W-1:0] rdata,
    output logic [DATA_W-1:0]            dout
);
    logic [DATA_W-1:0] merged;

    always_comb begin
        merged = '0;
        for (int b = 0; b < NBANK; b++)
            if (rvalid[b])
                merged = merged | rdata[b];
    end

    always_ff @(posedge clk) begin
        if (rst) dout <= '0;
        else     dout <= merged;
    end

    // R1: only one bank returns read data in a cycle
    p_single_return_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rvalid));

    // R6: no read return in flight means the output is idle
    p_idle_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (rvalid == '0) |=> (dout == '0));
endmodule

// File: rtl/ilv_mem4.sv
module ilv_mem4
    import ilv_mem4_pkg::*;
#(
    parameter int IDX_W   = 8,
    parameter int OCC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [15:0]       addr,
    input  logic [15:0]       wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [15:0]       rdata,
    output logic              stall,
    output logic [3:0]        busy,
    output logic              err
);
    localparam int IDX_LO = BANK_W + 1;

    mreq_t                        req;
    logic [NBANK-1:0]             acc;
    logic                         is_wr;
    logic [NBANK-1:0]             rv;
    logic [NBANK-1:0][DATA_W-1:0] rd_bank;
    logic [IDX_W-1:0]             idx;

    always_comb begin
        req.rd   = rd;
        req.wr   = wr;
        req.addr = addr;
        req.data = wdata;
    end

    assign idx = addr[IDX_LO +: IDX_W];

    mb_decode u_dec (
        .rst    (rst),
        .req    (req),
        .busy   (busy),
        .accept (acc),
        .is_wr  (is_wr),
        .stall  (stall),
        .err    (err)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        mb_bank #(.IDX_W(IDX_W), .OCC_CYC(OCC_CYC)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .accept (acc[g]),
            .is_wr  (is_wr),
            .idx    (idx),
            .wdata  (req.data),
            .busy   (busy[g]),
            .rvalid (rv[g]),
            .rdata  (rd_bank[g])
        );
    end

    mb_rdret u_ret (
        .clk    (clk),
        .rst    (rst),
        .rvalid (rv),
        .rdata  (rd_bank),
        .dout   (rdata)
    );

    // R1: at most one bank starts an access per cycle
    p_one_start_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc));

    // R7: a malformed request is never also reported as a stall
    p_stall_err_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(stall && err));

    // R9: a dropped request never makes more banks occupied
    p_reject_no_new_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (stall || err) |=> ($countones(busy) <= $past($countones(busy))));
endmodule

// File: tb/ilv_mem4_test.sv
module ilv_mem4_test;
    localparam int IDX_W = 8;
    localparam int WORDS = 4 << IDX_W;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr, wdata, rdata;
    logic        wr, rd, stall, err;
    logic [3:0]  busy;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] shadow [WORDS];
    int          bcnt [4];
    logic [15:0] e1, e2;

    always #5 clk = ~clk;

    ilv_mem4 #(.IDX_W(IDX_W)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .stall(stall), .busy(busy), .err(err)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] model_busy();
        logic [3:0] v;
        for (int b = 0; b < 4; b++) v[b] = (bcnt[b] != 0);
        return v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < WORDS; i++) shadow[i] = '0;
        for (int b = 0; b < 4; b++) bcnt[b] = 0;
        e1 = '0;
        e2 = '0;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic do_cycle(input logic r, input logic w,
                            input logic [15:0] a, input logic [15:0] d);
        logic       bad, hit, acc;
        int         b;
        logic [15:0] nxt;
        rd = r; wr = w; addr = a; wdata = d;
        #1;
        bad = (r && w) || ((r || w) && a[0]);
        b   = int'(a[2:1]);
        hit = (bcnt[b] != 0);
        acc = !bad && (r || w) && !hit;
        check("R3", "busy", 32'(busy), 32'(model_busy()));
        check("R4", "stall", 32'(stall), 32'(!bad && (r || w) && hit));
        check((r && w) ? "R7" : "R8", "err", 32'(err), 32'(bad));
        check("R6", "rdata", 32'(rdata), 32'(e2));
        nxt = (acc && r) ? shadow[a[IDX_W+2:1]] : 16'h0;
        e2 = e1;
        e1 = nxt;
        for (int k = 0; k < 4; k++) if (bcnt[k] != 0) bcnt[k]--;
        if (acc) bcnt[b] = 3;
        if (acc && w) shadow[a[IDX_W+2:1]] = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) do_cycle(1'b0, 1'b0, 16'h0, 16'h0);
    endtask

    task automatic do_reset();
        rst = 1'b1; rd = 1'b1; wr = 1'b1; addr = 16'h0003; wdata = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R2", "stall in reset", 32'(stall), 32'd0);
        check("R2", "err in reset", 32'(err), 32'd0);
        check("R2", "busy in reset", 32'(busy), 32'd0);
        check("R2", "rdata in reset", 32'(rdata), 32'd0);
        rst = 1'b0; rd = 1'b0; wr = 1'b0;
        model_clear();
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lf;
        rst = 1'b1; rd = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        model_clear();
        @(negedge clk);
        do_reset();

        // R1 R5 R10: sweep every stored word, banks in rotation, no stalls
        for (int i = 0; i < WORDS; i++)
            do_cycle(1'b0, 1'b1, 16'(i * 2), 16'(i * 16'h9E37 ^ 16'h5A5A));
        idle(3);
        for (int i = 0; i < WORDS; i++)
            do_cycle(1'b1, 1'b0, 16'(i * 2), 16'h0);
        idle(3);

        // R4: repeated hits on bank 0, stalled until the fourth cycle
        do_cycle(1'b1, 1'b0, 16'h0000, 16'h0);
        do_cycle(1'b0, 1'b1, 16'h0008, 16'hDEAD);   // stall, read data due next
        do_cycle(1'b0, 1'b1, 16'h0008, 16'hBEEF);   // stall while read returns
        do_cycle(1'b0, 1'b1, 16'h0002, 16'h1234);   // R5: other bank accepted
        do_cycle(1'b1, 1'b0, 16'h0008, 16'h0);      // N+4: accepted, R9 no write
        idle(4);

        // R7 R8: malformed requests leave timers and contents untouched
        do_cycle(1'b1, 1'b1, 16'h0010, 16'hAAAA);
        do_cycle(1'b0, 1'b1, 16'h0013, 16'hBBBB);
        do_cycle(1'b1, 1'b0, 16'h0015, 16'h0);
        do_cycle(1'b1, 1'b0, 16'h0010, 16'h0);
        do_cycle(1'b1, 1'b0, 16'h0012, 16'h0);
        do_cycle(1'b1, 1'b0, 16'h0014, 16'h0);
        idle(4);

        // mixed pseudo-random traffic: stalls, errors and returns overlap
        lf = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_cycle(lf[0], lf[1] & ~lf[2] & ~lf[3] | (lf[0] & lf[1] & lf[2] & lf[3]),
                     {lf[15:8], lf[8:3], 1'b0, lf[4] & lf[5] & lf[6] & lf[7]},
                     lf ^ 16'h3C3C);
        end
        idle(4);

        // R2: reset in the middle clears stored contents
        do_cycle(1'b0, 1'b1, 16'h0020, 16'h7777);
        do_cycle(1'b0, 1'b1, 16'h0022, 16'h8888);
        do_reset();
        do_cycle(1'b1, 1'b0, 16'h0020, 16'h0);
        do_cycle(1'b1, 1'b0, 16'h0022, 16'h0);
        do_cycle(1'b1, 1'b0, 16'h0004, 16'h0);
        idle(3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_900_000;
        n_chk++;
        n_fail++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule